// File: doc/BRIEF.md
# Five-Source Fixed-Priority Interrupt Controller

This block is the interrupt unit of a small 8-bit microcontroller core. It has five request sources: two active-low external pins, two timer rollover pulses, and one serial request. The serial request is the OR of a receive-done flag and a transmit-done flag, both held by the serial unit. Each request is latched into a flag. A source is offered to the core only when the global enable bit and that source's own enable bit are both set. When several sources are pending, the controller picks the one with the highest fixed rank and presents its vector address on registered outputs.

The core takes a request by pulsing `ack_i`. The controller then drops its request and raises `busy_o`. It clears a flag only for the source types whose flag hardware should clear. It offers nothing new until the core pulses `reti_i`.

Each external pin is sensed in one of two ways, chosen by a small mode register. In edge mode a falling transition is captured. In level mode the flag simply follows the pin.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a synchronous reset, `irq_o` and `busy_o` are 0, `flags_o` is 00000b, and the enable and mode registers are 0. All sources are therefore disabled and both pins are in level mode.
- R2: A source is requested only when enable bit 7 (global) and its own enable bit are both 1. The own-enable bits are: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial. `flags_o` uses the same bit order for bits 0 to 4.
- R3: When several enabled flags are pending, the winner follows this order, highest first: external 0, timer 0, external 1, timer 1, serial.
- R4: The vector is 0003H + 8 × rank, with rank 0 to 4 in the R3 order. That gives 0003H, 000BH, 0013H, 001BH and 0023H. It is valid whenever `irq_o` is 1.
- R5: When mode bit k is 1 (edge mode), the flag of external k sets after the pin is sampled high in one cycle and low in the next. A pulse one cycle wide is enough. The flag clears when that source is acknowledged. A rising transition sets nothing.
- R6: When mode bit k is 0 (level mode), the flag of external k equals the inverted pin, two clock edges after the pin changes. An acknowledge does not clear it. If the pin is still low after `reti_i`, the same source is requested again.
- R7: A one-cycle pulse on a timer rollover input sets that timer's flag at the next edge. The flag stays set until that timer is acknowledged, which clears it.
- R8: The serial flag equals `ser_rx_i | ser_tx_i` one edge later. An acknowledge never clears it.
- R9: An acknowledge taken while `irq_o` is 1 lowers `irq_o` and raises `busy_o` at the next edge. While `busy_o` is 1, `irq_o` stays 0, and `busy_o` falls on `reti_i`. An acknowledge while `irq_o` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one machine cycle per period |
| rst | input | 1 | Synchronous active-high reset |
| ext_n_i | input | 2 | External request pins, active low |
| tmr_ovf_i | input | 2 | Timer rollover pulses, one cycle wide |
| ser_rx_i | input | 1 | Serial receive-done flag |
| ser_tx_i | input | 1 | Serial transmit-done flag |
| en_we_i | input | 1 | Write strobe for the enable register |
| en_wdata_i | input | 8 | New enable register value |
| mode_we_i | input | 1 | Write strobe for the sense-mode register |
| mode_wdata_i | input | 2 | New mode bits, 1 = edge, 0 = level |
| ack_i | input | 1 | Core takes the presented vector |
| reti_i | input | 1 | Core returns from the service routine |
| irq_o | output | 1 | Request to the core |
| vec_o | output | 16 | Vector address of the winning source |
| busy_o | output | 1 | A service routine is in progress |
| flags_o | output | 5 | Latched request flags |

## Verification
The bench raises several sources in the same cycle and walks the acknowledge/return loop, so that every rank appears in turn. A wrong priority chain would present the vectors out of order. A wrong clear rule would make a cleared source repeat, or an uncleared source vanish. It also holds an external pin low in level mode across an acknowledge, where a design that cleared the flag would fail to request again after return. It then sends a single-cycle low pulse in edge mode, which a design demanding a longer low time would miss. Finally, it acknowledges while idle and raises requests while busy. A controller that accepted either would show a stray busy flag or a nested request.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned VEC_BASE   = 3;
  localparam int unsigned VEC_STRIDE = 8;
endpackage

// File: rtl/irqc_sense.sv
module irqc_sense (
  input  logic clk,
  input  logic rst,
  input  logic pin_n_i,
  input  logic edge_mode_i,
  input  logic clr_i,
  output logic flag_o
);
  logic smp_q, prev_q, fall;

  assign fall = prev_q & ~smp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q  <= 1'b1;
      prev_q <= 1'b1;
      flag_o <= 1'b0;
    end else begin
      smp_q  <= pin_n_i;
      prev_q <= smp_q;
      if (edge_mode_i) flag_o <= fall | (flag_o & ~clr_i);
      else             flag_o <= ~smp_q;
    end
  end
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb #(
  parameter int unsigned N  = 5,
  parameter int unsigned IW = 3,
  parameter int unsigned AW = 16,
  parameter int unsigned VB = 3,
  parameter int unsigned VS = 8
) (
  input  logic [N-1:0]  pend_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o,
  output logic [AW-1:0] vec_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
    vec_o = AW'(VB) + AW'(VS) * AW'(idx_o);
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int unsigned N_EXT = 2,
  parameter int unsigned AW    = 16,
  parameter int unsigned EN_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_EXT-1:0]      ext_n_i,
  input  logic [N_EXT-1:0]      tmr_ovf_i,
  input  logic                  ser_rx_i,
  input  logic                  ser_tx_i,
  input  logic                  en_we_i,
  input  logic [EN_W-1:0]       en_wdata_i,
  input  logic                  mode_we_i,
  input  logic [N_EXT-1:0]      mode_wdata_i,
  input  logic                  ack_i,
  input  logic                  reti_i,
  output logic                  irq_o,
  output logic [AW-1:0]         vec_o,
  output logic                  busy_o,
  output logic [2*N_EXT:0]      flags_o
);
  import irqc_pkg::*;

  localparam int unsigned NSRC = 2 * N_EXT + 1;
  localparam int unsigned IW   = $clog2(NSRC);

  logic [EN_W-1:0]  en_q;
  logic [N_EXT-1:0] mode_q;
  logic [NSRC-1:0]  flag, pend, clr;
  logic [IW-1:0]    sel_q, win_idx;
  logic [AW-1:0]    win_vec;
  logic             win_any, ack_take, irq_d;

  assign ack_take = ack_i & irq_o;
  assign pend     = flag & en_q[NSRC-1:0] & {NSRC{en_q[EN_W-1]}};
  assign irq_d    = win_any & ~busy_o & ~ack_take;
  assign flags_o  = flag;

  always_comb begin
    clr = '0;
    if (ack_take) begin
      for (int k = 0; k < int'(N_EXT); k++) begin
        if (sel_q == IW'(2 * k) && mode_q[k]) clr[2*k] = 1'b1;
        if (sel_q == IW'(2 * k + 1))          clr[2*k+1] = 1'b1;
      end
    end
  end

  genvar k;
  generate
    for (k = 0; k < N_EXT; k++) begin : g_src
      irqc_sense i_sense (
        .clk         (clk),
        .rst         (rst),
        .pin_n_i     (ext_n_i[k]),
        .edge_mode_i (mode_q[k]),
        .clr_i       (clr[2*k]),
        .flag_o      (flag[2*k])
      );

      always_ff @(posedge clk) begin
        if (rst) flag[2*k+1] <= 1'b0;
        else     flag[2*k+1] <= tmr_ovf_i[k] | (flag[2*k+1] & ~clr[2*k+1]);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) flag[NSRC-1] <= 1'b0;
    else     flag[NSRC-1] <= ser_rx_i | ser_tx_i;
  end

  irqc_arb #(
    .N  (NSRC),
    .IW (IW),
    .AW (AW),
    .VB (VEC_BASE),
    .VS (VEC_STRIDE)
  ) i_arb (
    .pend_i (pend),
    .any_o  (win_any),
    .idx_o  (win_idx),
    .vec_o  (win_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      mode_q <= '0;
      irq_o  <= 1'b0;
      vec_o  <= '0;
      sel_q  <= '0;
      busy_o <= 1'b0;
    end else begin
      if (en_we_i)   en_q   <= en_wdata_i;
      if (mode_we_i) mode_q <= mode_wdata_i;
      irq_o  <= irq_d;
      if (irq_d) begin
        vec_o <= win_vec;
        sel_q <= win_idx;
      end
      busy_o <= ack_take | (busy_o & ~reti_i);
    end
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int unsigned NSRC = 5,
  parameter int unsigned AW   = 16,
  parameter int unsigned EN_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            irq_o,
  input logic            busy_o,
  input logic            ack_i,
  input logic [AW-1:0]   vec_o,
  input logic [NSRC-1:0] flags_o,
  input logic            ser_rx_i,
  input logic            ser_tx_i,
  input logic [EN_W-1:0] en_q
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!irq_o && !busy_o && flags_o == '0)); // R1
  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (rst) !en_q[EN_W-1] |=> !irq_o); // R2
  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (rst) irq_o |-> (vec_o[2:0] == 3'd3 && vec_o <= AW'(16'h0023))); // R4
  AST_ACK_TAKES:   assert property (@(posedge clk) disable iff (rst) (ack_i && irq_o) |=> (!irq_o && busy_o)); // R9
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst) busy_o |=> !irq_o); // R9
  AST_SER_HOLDS:   assert property (@(posedge clk) disable iff (rst) (ser_rx_i || ser_tx_i) |=> flags_o[NSRC-1]); // R8
endmodule

bind irq_prio_ctrl irqc_chk #(.NSRC(2 * N_EXT + 1), .AW(AW), .EN_W(EN_W)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .irq_o    (irq_o),
  .busy_o   (busy_o),
  .ack_i    (ack_i),
  .vec_o    (vec_o),
  .flags_o  (flags_o),
  .ser_rx_i (ser_rx_i),
  .ser_tx_i (ser_tx_i),
  .en_q     (en_q)
);

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  ext_n = 2'b11, ovf = 2'b00, mode_d = 2'b00;
  logic        rx = 1'b0, tx = 1'b0, en_we = 1'b0, mode_we = 1'b0, ack = 1'b0, reti = 1'b0;
  logic [7:0]  en_d = 8'h00;
  logic        irq_o, busy_o;
  logic [15:0] vec_o;
  logic [4:0]  flags_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk(clk), .rst(rst), .ext_n_i(ext_n), .tmr_ovf_i(ovf), .ser_rx_i(rx), .ser_tx_i(tx),
    .en_we_i(en_we), .en_wdata_i(en_d), .mode_we_i(mode_we), .mode_wdata_i(mode_d),
    .ack_i(ack), .reti_i(reti), .irq_o(irq_o), .vec_o(vec_o), .busy_o(busy_o), .flags_o(flags_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit [7:0] m_en; bit [1:0] m_mode, m_smp, m_prev; bit [4:0] m_flag;
  bit m_irq, m_busy; int m_vec, m_sel;

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_mode = 0; m_flag = 0; m_smp = 2'b11; m_prev = 2'b11;
      m_irq = 0; m_busy = 0; m_vec = 0; m_sel = 0;
    end else begin
      bit take; bit [4:0] pend, nf; int hit;
      take = ack && m_irq;
      pend = m_flag & m_en[4:0] & {5{m_en[7]}};
      hit = -1;
      for (int i = 4; i >= 0; i--) if (pend[i]) hit = i;
      nf = m_flag;
      if (take && (m_sel == 1 || m_sel == 3)) nf[m_sel] = 1'b0;
      if (take && (m_sel == 0 || m_sel == 2) && m_mode[m_sel / 2]) nf[m_sel] = 1'b0;
      if (ovf[0]) nf[1] = 1'b1;
      if (ovf[1]) nf[3] = 1'b1;
      nf[4] = rx | tx;
      for (int e = 0; e < 2; e++) begin
        if (m_mode[e]) begin
          if (m_prev[e] && !m_smp[e]) nf[2*e] = 1'b1;
        end else nf[2*e] = !m_smp[e];
      end
      m_prev = m_smp; m_smp = ext_n;
      m_irq = (hit >= 0) && !m_busy && !take;
      if (m_irq) begin m_vec = 3 + 8 * hit; m_sel = hit; end
      m_busy = take || (m_busy && !reti);
      m_flag = nf;
      if (en_we) m_en = en_d;
      if (mode_we) m_mode = mode_d;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(irq_o === m_irq, "R3 model irq", int'(irq_o), int'(m_irq));
      if (m_irq) chk(vec_o === m_vec[15:0], "R4 model vector", int'(vec_o), m_vec);
      chk(busy_o === m_busy, "R9 model busy", int'(busy_o), int'(m_busy));
      chk(flags_o === m_flag, "R5 model flags", int'(flags_o), int'(m_flag));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr_en(input logic [7:0] v);
    en_we = 1'b1; en_d = v; step(1); en_we = 1'b0;
  endtask
  task automatic wr_mode(input logic [1:0] v);
    mode_we = 1'b1; mode_d = v; step(1); mode_we = 1'b0;
  endtask
  task automatic do_ack();
    ack = 1'b1; step(1); ack = 1'b0;
  endtask
  task automatic do_reti();
    reti = 1'b1; step(1); reti = 1'b0; step(2);
  endtask
  task automatic expect_vec(input string tag, input int v);
    chk(irq_o === 1'b1, tag, int'(irq_o), 1);
    chk(vec_o === v[15:0], tag, int'(vec_o), v);
  endtask

  initial begin
    step(3); rst = 1'b0; step(1);
    chk(irq_o === 1'b0 && busy_o === 1'b0, "R1 reset outputs", int'({irq_o, busy_o}), 0);
    chk(flags_o === 5'b0, "R1 reset flags", int'(flags_o), 0);

    ovf[0] = 1'b1; step(1); ovf[0] = 1'b0; step(2);
    chk(flags_o[1] === 1'b1, "R7 timer flag set", int'(flags_o[1]), 1);
    chk(irq_o === 1'b0, "R2 disabled after reset", int'(irq_o), 0);
    wr_en(8'h02); step(3);
    chk(irq_o === 1'b0, "R2 no global enable", int'(irq_o), 0);
    wr_en(8'h82); step(3);
    expect_vec("R7 timer0 vector", 16'h000B);
    do_ack();
    chk(irq_o === 1'b0 && busy_o === 1'b1, "R9 ack takes", int'({irq_o, busy_o}), 1);
    chk(flags_o[1] === 1'b0, "R7 timer flag cleared", int'(flags_o[1]), 0);
    wr_en(8'h8A);
    ovf[1] = 1'b1; step(1); ovf[1] = 1'b0; step(3);
    chk(irq_o === 1'b0, "R9 blocked while busy", int'(irq_o), 0);
    do_reti();
    expect_vec("R4 timer1 vector", 16'h001B);
    do_ack(); do_reti();
    do_ack();
    chk(busy_o === 1'b0, "R9 idle ack ignored", int'(busy_o), 0);

    wr_mode(2'b11); wr_en(8'h9F);
    rx = 1'b1; ovf = 2'b11; ext_n[1] = 1'b0; step(1); ovf = 2'b00; step(4);
    expect_vec("R3 timer0 first", 16'h000B);
    do_ack(); do_reti();
    expect_vec("R3 ext1 second", 16'h0013);
    do_ack();
    chk(flags_o[2] === 1'b0, "R5 edge flag cleared", int'(flags_o[2]), 0);
    do_reti();
    expect_vec("R3 timer1 third", 16'h001B);
    do_ack(); do_reti();
    expect_vec("R3 serial last", 16'h0023);
    do_ack();
    chk(flags_o[4] === 1'b1, "R8 serial kept on ack", int'(flags_o[4]), 1);
    do_reti();
    expect_vec("R8 serial again", 16'h0023);
    rx = 1'b0; tx = 1'b1; step(2);
    chk(flags_o[4] === 1'b1, "R8 transmit flag", int'(flags_o[4]), 1);
    tx = 1'b0; ext_n[1] = 1'b1; step(3);
    chk(flags_o[4] === 1'b0 && irq_o === 1'b0, "R8 serial gone", int'({flags_o[4], irq_o}), 0);
    chk(flags_o[2] === 1'b0, "R5 rising edge ignored", int'(flags_o[2]), 0);

    ext_n[0] = 1'b0; step(1); ext_n[0] = 1'b1; step(4);
    expect_vec("R5 short pulse ext0", 16'h0003);
    do_ack();
    chk(flags_o[0] === 1'b0, "R5 ext0 cleared", int'(flags_o[0]), 0);
    do_reti();
    chk(irq_o === 1'b0, "R5 single event", int'(irq_o), 0);

    wr_mode(2'b00);
    ext_n[0] = 1'b0; step(4);
    expect_vec("R6 level ext0", 16'h0003);
    do_ack();
    chk(flags_o[0] === 1'b1, "R6 level kept on ack", int'(flags_o[0]), 1);
    do_reti();
    expect_vec("R6 level requests again", 16'h0003);
    ext_n[0] = 1'b1; step(4);
    chk(irq_o === 1'b0 && flags_o[0] === 1'b0, "R6 level follows pin", int'({irq_o, flags_o[0]}), 0);

    wr_en(8'h8F); rx = 1'b1; step(3);
    chk(irq_o === 1'b0, "R2 serial bit4 off", int'(irq_o), 0);
    wr_en(8'h90); step(3);
    expect_vec("R2 serial bit4 on", 16'h0023);
    rx = 1'b0; step(3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R9 actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule